// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the integer execute stage of a 32-bit load/store processor core. Each cycle it can accept one operation: two register operands, a 5-bit fixed shift count, a 16-bit immediate, an operation code and an immediate-mode select. It returns one registered result a clock later. It covers fixed and variable shifts, trapping and wrapping add and subtract, the four bitwise operations, signed and unsigned set-less-than, and loading an immediate into the upper half-word.

When the immediate-mode select is high, the second operand comes from the immediate instead of the register. The immediate is zero-extended for the bitwise operations and sign-extended for arithmetic and compare operations. A trapping add or subtract that overflows as a signed value raises an exception flag and drops the write enable, so the destination register keeps its old value.

Top module: `alu_ex_unit`

## Requirements
- R1: The op code is 5 bits: 0 SLL, 1 SRL, 2 SRA, 3 SLLV, 4 SRLV, 5 SRAV, 6 ADD, 7 ADDU, 8 SUB, 9 SUBU, 10 AND, 11 OR, 12 XOR, 13 NOR, 14 SLT, 15 SLTU, 16 LUI. `out_valid` equals `in_valid` delayed by one clock. A cycle with `in_valid` low leaves `result` unchanged and drives `ovf` and `wr_en` low on the next cycle.
- R2: After reset, `out_valid`, `result`, `ovf` and `wr_en` are all zero.
- R3: SLL, SRL and SRA shift `src_b` by `shamt`. SLL and SRL fill with zeros. SRA fills with copies of bit 31.
- R4: SLLV, SRLV and SRAV shift `src_b` by `src_a[4:0]`. The upper bits of `src_a` are ignored.
- R5: ADD and SUB raise `ovf` when the signed 32-bit result overflows. In that case `wr_en` is low.
- R6: ADDU and SUBU never raise `ovf`. Their result wraps modulo 2^32, and so does the result of an overflowing ADD or SUB.
- R7: AND, OR, XOR and NOR perform the bitwise operation. NOR is the inverse of OR.
- R8: SLT compares as signed and SLTU compares as unsigned. The result is 1 when the first operand is less than the second, otherwise 0.
- R9: With `use_imm` high, the second operand is `imm` sign-extended for ADD, ADDU, SUB, SUBU, SLT and SLTU, and zero-extended for AND, OR, XOR and NOR. Shifts ignore `use_imm`.
- R10: LUI returns `{imm, 16'h0000}`, whatever the register operands are.
- R11: Op codes 17 to 31 return a result of 0 with `wr_en` low and `ovf` low.
- R12: Every valid, defined operation that does not overflow drives `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code |
| use_imm | input | 1 | Second operand taken from the extended immediate |
| src_a | input | 32 | First register operand; also the variable shift count |
| src_b | input | 32 | Second register operand; also the value that is shifted |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Fixed shift count |
| out_valid | output | 1 | The result registers hold a new result |
| result | output | 32 | Registered result |
| ovf | output | 1 | Signed overflow exception on ADD or SUB |
| wr_en | output | 1 | The destination may be written |

## Verification
The bench aims at the places where similar operations differ. SRA is run on a negative value, where a zero fill gives a positive result. Variable shifts are given a count with high bits set, so a design that uses the whole register produces zero. ADD and SUB are pushed across the signed limits, and ADDU and SUBU get the same operands, which catches a missing or misplaced trap and a write enable that stays high on overflow. Compares and immediates use all-ones patterns: -1 against 1 tells signed from unsigned ordering, and an immediate of 0xFFFF shows whether the extension matches the operation. A bubble cycle, an undefined op code and back-to-back issue expose a result register that does not hold its value or a valid that is out of step.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SLL  = 5'd0,  OP_SRL  = 5'd1,  OP_SRA  = 5'd2,
    OP_SLLV = 5'd3,  OP_SRLV = 5'd4,  OP_SRAV = 5'd5,
    OP_ADD  = 5'd6,  OP_ADDU = 5'd7,  OP_SUB  = 5'd8,
    OP_SUBU = 5'd9,  OP_AND  = 5'd10, OP_OR   = 5'd11,
    OP_XOR  = 5'd12, OP_NOR  = 5'd13, OP_SLT  = 5'd14,
    OP_SLTU = 5'd15, OP_LUI  = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              ovf;
  } addsub_t;

  // two's complement add or subtract with carry out and signed overflow
  function automatic addsub_t f_addsub(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b,
                                       input logic              sub);
    addsub_t           r;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;
    b_eff   = sub ? ~b : b;
    wide    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    r.sum   = wide[DATA_W-1:0];
    r.carry = wide[DATA_W];
    r.ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) &&
              (r.sum[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction

  function automatic logic f_is_logic(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sign_mode,
  output logic [DATA_W-1:0] ext
);
  localparam int PAD_W = DATA_W - IMM_W;
  logic fill;
  assign fill = sign_mode & imm[IMM_W-1];
  assign ext  = {{PAD_W{fill}}, imm};
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [SH_W-1:0]   amount,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] shifted
);
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic              fill;

  // left shifts reuse the right-shift network on the bit-reversed value
  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_in[i] = value[DATA_W-1-i];
  end

  assign fill     = arith & ~left & value[DATA_W-1];
  assign stage[0] = left ? rev_in : value;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amount[k] ? {{D{fill}}, stage[k][DATA_W-1:D]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_out[i] = stage[SH_W][DATA_W-1-i];
  end

  assign shifted = left ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_raw,
  output logic              lt_s,
  output logic              lt_u
);
  addsub_t r;
  assign r       = f_addsub(a, b, sub);
  assign sum     = r.sum;
  assign ovf_raw = r.ovf;
  // a - b: borrow means unsigned less; sign xor overflow means signed less
  assign lt_u    = ~r.carry;
  assign lt_s    = r.sum[DATA_W-1] ^ r.ovf;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_ex_unit.sv
module alu_ex_unit
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [4:0]        shamt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              wr_en
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int LOW_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext, opnd_b;
  logic [DATA_W-1:0] sh_out, as_out, lg_out;
  logic [SH_W-1:0]   sh_amt;
  logic              sign_mode, var_shift, sh_left, sh_arith, do_sub;
  logic              ovf_raw, lt_s, lt_u;
  logic [1:0]        lg_sel;

  // named internal events, observed by the checker
  logic              trap_op;
  logic              legal_op;
  logic              nxt_ovf;
  logic              nxt_wen;
  logic [DATA_W-1:0] nxt_result;

  assign sign_mode = ~f_is_logic(op);
  assign opnd_b    = use_imm ? imm_ext : src_b;
  assign var_shift = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign sh_left   = (op == OP_SLL)  || (op == OP_SLLV);
  assign sh_arith  = (op == OP_SRA)  || (op == OP_SRAV);
  assign sh_amt    = var_shift ? src_a[SH_W-1:0] : shamt[SH_W-1:0];
  assign do_sub    = (op == OP_SUB) || (op == OP_SUBU) ||
                     (op == OP_SLT) || (op == OP_SLTU);
  assign lg_sel    = op[1:0] - 2'd2;
  assign trap_op   = (op == OP_ADD) || (op == OP_SUB);
  assign legal_op  = op <= OP_LUI;

  alu_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
    .imm(imm), .sign_mode(sign_mode), .ext(imm_ext)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .value(src_b), .amount(sh_amt), .left(sh_left),
    .arith(sh_arith), .shifted(sh_out)
  );

  alu_addsub u_addsub (
    .a(src_a), .b(opnd_b), .sub(do_sub), .sum(as_out),
    .ovf_raw(ovf_raw), .lt_s(lt_s), .lt_u(lt_u)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(src_a), .b(opnd_b), .sel(lg_sel), .y(lg_out)
  );

  always_comb begin
    nxt_result = '0;
    case (op)
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV: nxt_result = sh_out;
      OP_ADD, OP_ADDU,
      OP_SUB, OP_SUBU:           nxt_result = as_out;
      OP_AND, OP_OR,
      OP_XOR, OP_NOR:            nxt_result = lg_out;
      OP_SLT:                    nxt_result = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:                   nxt_result = {{(DATA_W-1){1'b0}}, lt_u};
      OP_LUI:                    nxt_result = {imm, {LOW_W{1'b0}}};
      default:                   nxt_result = '0;
    endcase
  end

  assign nxt_ovf = trap_op & ovf_raw;
  assign nxt_wen = legal_op & ~nxt_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      ovf       <= in_valid & nxt_ovf;
      wr_en     <= in_valid & nxt_wen;
      if (in_valid) result <= nxt_result;
    end
  end
endmodule

// File: rtl/alu_ex_chk.sv
module alu_ex_chk
  import alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op,
  input logic              use_imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              ovf,
  input logic              wr_en,
  input logic              trap_op,
  input logic              legal_op
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !ovf));
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R5
  ovf_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (!wr_en && out_valid));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !trap_op) |=> !ovf);
  // R8
  slt_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_SLT || op == OP_SLTU)) |=> (result[DATA_W-1:1] == '0));
  // R10
  lui_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_LUI) |=> (result[DATA_W-IMM_W-1:0] == '0 && wr_en));
  // R11
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal_op) |=> (result == '0 && !wr_en && !ovf));
  // R12
  wen_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal_op && !trap_op) |=> wr_en);
endmodule

bind alu_ex_unit alu_ex_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
  .out_valid(out_valid), .result(result), .ovf(ovf), .wr_en(wr_en),
  .trap_op(trap_op), .legal_op(legal_op)
);

// File: tb/alu_ex_unit_test.sv
module alu_ex_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic        out_valid, ovf, wr_en;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] q_res[$];
  logic        q_ovf[$];
  logic        q_wen[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  alu_ex_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
    .out_valid(out_valid), .result(result), .ovf(ovf), .wr_en(wr_en)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, written from the requirements
  task automatic model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic ui, input logic [4:0] sa,
                       output logic [31:0] r, output logic v, output logic w);
    logic [31:0] sx, zx, bs, bl;
    longint      wide;
    sx = 32'($signed(im));
    zx = {16'h0, im};
    bs = ui ? sx : b;
    bl = ui ? zx : b;
    r = 0; v = 0; w = (o <= 16);
    case (o)
      0:  r = b << sa;
      1:  r = b >> sa;
      2:  r = 32'($signed(b) >>> sa);
      3:  r = b << a[4:0];
      4:  r = b >> a[4:0];
      5:  r = 32'($signed(b) >>> a[4:0]);
      6, 7: begin
        r = a + bs;
        wide = longint'($signed(a)) + longint'($signed(bs));
        v = (o == 6) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      8, 9: begin
        r = a - bs;
        wide = longint'($signed(a)) - longint'($signed(bs));
        v = (o == 8) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      10: r = a & bl;
      11: r = a | bl;
      12: r = a ^ bl;
      13: r = ~(a | bl);
      14: r = ($signed(a) < $signed(bs)) ? 1 : 0;
      15: r = (a < bs) ? 1 : 0;
      16: r = {im, 16'h0};
      default: r = 0;
    endcase
    if (v) w = 0;
  endtask

  task automatic send(string tag, logic [4:0] o, logic [31:0] a, logic [31:0] b,
                      logic [15:0] im, logic ui, logic [4:0] sa);
    logic [31:0] r; logic v, w;
    model(o, a, b, im, ui, sa, r, v, w);
    q_res.push_back(r); q_ovf.push_back(v); q_wen.push_back(w); q_tag.push_back(tag);
    op = o; src_a = a; src_b = b; imm = im; use_imm = ui; shamt = sa; in_valid = 1'b1;
    @(negedge clk);
  endtask

  // monitor: compares each valid output with the oldest expected item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q_res.size() == 0) begin
          total++; bad++;
          $display("FAIL R1: unexpected out_valid actual=1 expected=0");
        end else begin
          string t;
          t = q_tag.pop_front();
          check({t, " result"}, result, q_res.pop_front());
          check({t, " ovf"}, {31'b0, ovf}, {31'b0, q_ovf.pop_front()});
          check({t, " wr_en"}, {31'b0, wr_en}, {31'b0, q_wen.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 out_valid", {31'b0, out_valid}, 0);
    check("R2 result", result, 0);
    check("R2 ovf", {31'b0, ovf}, 0);
    check("R2 wr_en", {31'b0, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 fixed shifts
    send("R3 sll", 5'd0, 32'hFFFF_FFFF, 32'h8000_00F1, 16'h0, 0, 5'd4);
    send("R3 srl", 5'd1, 32'h0, 32'h8000_0000, 16'h0, 0, 5'd31);
    send("R3 sra neg", 5'd2, 32'h0, 32'h8000_0000, 16'h0, 0, 5'd4);
    send("R3 sra zero", 5'd2, 32'h0, 32'hC000_0001, 16'h0, 0, 5'd0);
    send("R3 sra pos", 5'd2, 32'h0, 32'h7000_0000, 16'h0, 0, 5'd8);
    // R4 variable shifts, upper bits of src_a ignored
    send("R4 sllv", 5'd3, 32'hFFFF_FFE5, 32'h0000_0003, 16'h0, 0, 5'd9);
    send("R4 srlv", 5'd4, 32'h1234_5663, 32'hF000_0000, 16'h0, 0, 5'd0);
    send("R4 srav", 5'd5, 32'h8000_001F, 32'h8000_0000, 16'h0, 0, 5'd1);
    // R5 trapping arithmetic
    send("R5 add ovf", 5'd6, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 5'd0);
    send("R5 add neg ovf", 5'd6, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 0, 5'd0);
    send("R5 add ok", 5'd6, 32'h7FFF_FFFE, 32'h1, 16'h0, 0, 5'd0);
    send("R5 sub ovf", 5'd8, 32'h8000_0000, 32'h1, 16'h0, 0, 5'd0);
    send("R5 sub ok", 5'd8, 32'h5, 32'h9, 16'h0, 0, 5'd0);
    // R6 wrapping arithmetic
    send("R6 addu", 5'd7, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 5'd0);
    send("R6 subu", 5'd9, 32'h8000_0000, 32'h1, 16'h0, 0, 5'd0);
    // R7 bitwise
    send("R7 and", 5'd10, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 0, 5'd0);
    send("R7 or", 5'd11, 32'hF0F0_1234, 32'h0F00_0001, 16'h0, 0, 5'd0);
    send("R7 xor", 5'd12, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 0, 5'd0);
    send("R7 nor", 5'd13, 32'h0000_00F0, 32'h0F00_0000, 16'h0, 0, 5'd0);
    // R8 compares
    send("R8 slt", 5'd14, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 5'd0);
    send("R8 sltu", 5'd15, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 5'd0);
    send("R8 slt ovf case", 5'd14, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 5'd0);
    send("R8 sltu eq", 5'd15, 32'h42, 32'h42, 16'h0, 0, 5'd0);
    // R9 immediates
    send("R9 addi sext", 5'd6, 32'h10, 32'h0, 16'hFFFF, 1, 5'd0);
    send("R9 andi zext", 5'd10, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1, 5'd0);
    send("R9 ori zext", 5'd11, 32'h0, 32'hFFFF_FFFF, 16'h8001, 1, 5'd0);
    send("R9 sltiu sext", 5'd15, 32'h1234, 32'h0, 16'hFFFF, 1, 5'd0);
    send("R9 slti sext", 5'd14, 32'h0, 32'h0, 16'h8000, 1, 5'd0);
    send("R9 shift ignores imm", 5'd0, 32'h0, 32'h1, 16'hFFFF, 1, 5'd3);
    // R10 load upper
    send("R10 lui", 5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 0, 5'd7);
    send("R10 lui imm", 5'd16, 32'h1, 32'h2, 16'h8001, 1, 5'd0);
    // R11 undefined codes
    send("R11 undef17", 5'd17, 32'h1, 32'h2, 16'h3, 0, 5'd1);
    send("R11 undef31", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1, 5'd31);
    // R12 write enable on normal ops
    send("R12 addu wen", 5'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 5'd0);

    // R1 bubble: result holds, flags low
    send("R1 before bubble", 5'd11, 32'h0000_00A5, 32'h0000_5A00, 16'h0, 0, 5'd0);
    held = 32'h0000_5AA5;
    in_valid = 1'b0; op = 5'd8; src_a = 32'h8000_0000; src_b = 32'h1;
    @(negedge clk);
    check("R1 bubble out_valid", {31'b0, out_valid}, 0);
    check("R1 bubble wr_en", {31'b0, wr_en}, 0);
    check("R1 bubble ovf", {31'b0, ovf}, 0);
    check("R1 bubble result", result, held);
    @(negedge clk);
    check("R1 bubble hold2", result, held);

    send("R1 after bubble", 5'd9, 32'h3, 32'h5, 16'h0, 0, 5'd0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 queue drained", q_res.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule